// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Switch Controller

This block turns a three-wire serial stream into eight on/off channel enables. The wires are a data line, a shift clock and a load strobe. Bits enter an internal shift register on each rising shift-clock edge. A rising strobe edge copies the shift register into a holding register, and the holding register drives the channel enables. The last shift stage is also presented on a cascade output. Several blocks can therefore share one clock and one strobe, with the cascade output of one feeding the data input of the next.

Every serial input and every control input is slow and asynchronous to the block. Each one passes through a synchronizer in a fast system clock domain, and the block finds the shift-clock and strobe edges there. A clear input empties both registers. A shutdown input blanks all channels, and pulsing it gives PWM dimming. An over-temperature flag also blanks all channels, and the channels come back by themselves once the flag drops.

Top module: `serial_switch_bank`

## Requirements
- R1: After system reset, with the clear input held low during start-up, all channel enables are 0 and the cascade output is 0.
- R2: On each rising shift-clock edge the sampled data bit enters stage 0 and every stage moves up by one. The first of eight bits sent therefore controls channel 7, and the eighth controls channel 0.
- R3: A rising strobe edge copies the shift register into the holding register. The channel enables then keep that value while further bits are shifted in, until the next rising strobe edge.
- R4: A holding-register bit of 1 drives its channel enable to 1 (on). A bit of 0 drives it to 0 (off).
- R5: While the active-low clear input is 0, the shift register and the holding register are both 0. A strobe given after clear is released, with no new bits shifted in, leaves all channels at 0.
- R6: While shutdown is 1, all channel enables are 0 whatever the holding register contains. When shutdown returns to 0, the held pattern reappears with its value unchanged.
- R7: While the over-temperature flag is 1, all channel enables are 0. When the flag clears, the held pattern returns with no other action needed.
- R8: The cascade output shows shift stage 7 (the oldest bit). It changes only on a falling shift-clock edge and stays unchanged across the rising edge.
- R9: When two blocks are chained and share clock and strobe, 16 clock pulses followed by one strobe load all 16 channels. The first bit sent lands in the far block's channel 7.
- R10: If a rising strobe edge and a rising shift-clock edge are detected in the same system cycle, the shift happens first. The holding register then takes the already-shifted value.
- R11: Input changes reach the outputs through a synchronizer of SYNC_DEPTH flops. The system clock must run at least 8 times faster than the shift clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for sampling |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| sdata_in | input | 1 | Serial data, asynchronous |
| strobe_in | input | 1 | Load strobe; a rising edge loads the holding register |
| clear_n_in | input | 1 | Active-low clear of the shift and holding registers |
| off_in | input | 1 | Shutdown; 1 forces every channel off |
| hot_in | input | 1 | Over-temperature flag; 1 forces every channel off |
| chan_on | output | WIDTH | Channel enables, 1 = on |
| cascade_out | output | 1 | Last shift stage, updated on the falling shift-clock edge |

## Verification
Five properties are checked on every cycle:
- shutdown and over-temperature each blank the channels;
- the holding register changes only on a strobe edge or a clear;
- the cascade output moves only on a falling clock edge;
- clear empties both registers;
- each detected rising clock edge puts the sampled data bit into stage 0.

Some behaviour can only be shown by the bench scenarios:
- bit ordering across a whole byte;
- loading 16 channels through a two-block chain;
- the same-cycle strobe-and-clock ordering;
- automatic recovery of the held pattern after shutdown or over-temperature.

// File: rtl/serial_switch_bank.sv
module serial_switch_bank #(
  parameter int WIDTH      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_in,
  input  logic             sdata_in,
  input  logic             strobe_in,
  input  logic             clear_n_in,
  input  logic             off_in,
  input  logic             hot_in,
  output logic [WIDTH-1:0] chan_on,
  output logic             cascade_out
);

  localparam int NIN = 6;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] sync_q [SYNC_DEPTH];
  logic [NIN-1:0] synced;

  assign raw    = {hot_in, off_in, clear_n_in, strobe_in, sdata_in, sclk_in};
  assign synced = sync_q[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_DEPTH; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_DEPTH; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  logic sclk_s, data_s, strobe_s, clr_s, off_s, hot_s;
  assign {hot_s, off_s, clr_s, strobe_s, data_s, sclk_s} = synced;

  logic sclk_d, strobe_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      strobe_d <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      strobe_d <= strobe_s;
    end
  end

  logic sclk_rise, sclk_fall, strobe_rise;
  assign sclk_rise   =  sclk_s & ~sclk_d;
  assign sclk_fall   = ~sclk_s &  sclk_d;
  assign strobe_rise =  strobe_s & ~strobe_d;

  logic [WIDTH-1:0] sh, hold, sh_next;
  assign sh_next = sclk_rise ? {sh[WIDTH-2:0], data_s} : sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh          <= '0;
      hold        <= '0;
      cascade_out <= 1'b0;
    end else if (!clr_s) begin
      sh          <= '0;
      hold        <= '0;
      cascade_out <= 1'b0;
    end else begin
      sh <= sh_next;
      if (strobe_rise) hold <= sh_next;
      if (sclk_fall) cascade_out <= sh[WIDTH-1];
    end
  end

  assign chan_on = (off_s || hot_s) ? '0 : hold;

  // R6
  off_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_s |-> (chan_on == '0));

  // R7
  hot_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot_s |-> (chan_on == '0));

  // R3
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_rise && clr_s) |=> $stable(hold));

  // R8
  casc_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && clr_s) |=> $stable(cascade_out));

  // R5
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_s |=> (sh == '0 && hold == '0));

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && clr_s) |=> (sh[0] == $past(data_s)));

endmodule

// File: tb/test_serial_switch_bank.sv
`timescale 1ns/1ps
module test_serial_switch_bank;
  localparam int W = 8;
  localparam int GAP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, strobe = 1'b0, clear_n = 1'b0, off = 1'b0, hot = 1'b0;
  logic [W-1:0] chan_on, far_chan;
  logic cascade_out, far_casc;

  always #2.5 clk = ~clk;

  serial_switch_bank #(.WIDTH(W), .SYNC_DEPTH(2)) i_serial_switch_bank (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sdata_in(sdata), .strobe_in(strobe),
    .clear_n_in(clear_n), .off_in(off), .hot_in(hot),
    .chan_on(chan_on), .cascade_out(cascade_out));

  serial_switch_bank #(.WIDTH(W), .SYNC_DEPTH(2)) i_serial_switch_bank_far (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sdata_in(cascade_out), .strobe_in(strobe),
    .clear_n_in(clear_n), .off_in(1'b0), .hot_in(1'b0),
    .chan_on(far_chan), .cascade_out(far_casc));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [W-1:0] m_sh = '0, m_hold = '0;
  logic m_casc = 1'b0;

  function automatic logic [W-1:0] exp_chan(logic [W-1:0] h, logic o, logic t);
    return (o || t) ? '0 : h;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sdata = b;
    settle(GAP);
    sclk = 1'b1;
    m_sh = {m_sh[W-2:0], b};
    settle(GAP);
    chk("R8 cascade steady over rising edge", {7'd0, cascade_out}, {7'd0, m_casc});
    sclk = 1'b0;
    m_casc = m_sh[W-1];
    settle(GAP);
    chk("R8 cascade after falling edge", {7'd0, cascade_out}, {7'd0, m_casc});
  endtask

  task automatic send_byte(logic [W-1:0] v);
    for (int i = W-1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic do_latch();
    strobe = 1'b1;
    m_hold = m_sh;
    settle(GAP);
    strobe = 1'b0;
    settle(GAP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    int unsigned r;
    r = $urandom(32'd4242);
    settle(3);
    rst_n = 1'b1;
    settle(GAP);
    chk("R1 reset channels", chan_on, '0);
    chk("R1 reset cascade", {7'd0, cascade_out}, '0);
    clear_n = 1'b1;
    settle(GAP);

    send_byte(8'b1000_0000);
    do_latch();
    chk("R2 first bit drives channel 7", chan_on, 8'h80);
    send_byte(8'b0000_0001);
    chk("R3 shifting leaves held value", chan_on, 8'h80);
    do_latch();
    chk("R2 eighth bit drives channel 0", chan_on, 8'h01);

    send_byte(8'hA5);
    do_latch();
    chk("R4 ones on zeros off", chan_on, 8'hA5);

    off = 1'b1; settle(GAP);
    chk("R6 shutdown blanks", chan_on, '0);
    off = 1'b0; settle(GAP);
    chk("R6 shutdown release restores", chan_on, 8'hA5);
    hot = 1'b1; settle(GAP);
    chk("R7 over-temp blanks", chan_on, '0);
    hot = 1'b0; settle(GAP);
    chk("R7 auto resume", chan_on, 8'hA5);
    for (int k = 0; k < 4; k++) begin
      off = 1'b1; settle(3);
      chk("R6 PWM low phase", chan_on, '0);
      off = 1'b0; settle(3);
      chk("R6 PWM high phase", chan_on, 8'hA5);
    end

    clear_n = 1'b0; settle(GAP);
    chk("R5 clear blanks", chan_on, '0);
    chk("R5 clear cascade", {7'd0, cascade_out}, '0);
    clear_n = 1'b1; settle(GAP);
    m_sh = '0; m_hold = '0; m_casc = 1'b0;
    do_latch();
    chk("R5 shift register emptied by clear", chan_on, '0);

    send_byte(8'h3C);
    do_latch();
    chk("R10 setup byte", chan_on, 8'h3C);
    sdata = 1'b1;
    settle(GAP);
    sclk = 1'b1; strobe = 1'b1;
    m_sh = {m_sh[W-2:0], 1'b1};
    settle(GAP);
    chk("R10 latch takes shifted value", chan_on, 8'h79);
    sclk = 1'b0; strobe = 1'b0;
    m_casc = m_sh[W-1];
    settle(GAP);
    m_hold = m_sh;

    clear_n = 1'b0; settle(GAP);
    clear_n = 1'b1; settle(GAP);
    m_sh = '0; m_casc = 1'b0;
    send_byte(8'hC3);
    send_byte(8'h5A);
    do_latch();
    chk("R9 near block gets last byte", chan_on, 8'h5A);
    chk("R9 far block gets first byte", far_chan, 8'hC3);

    for (int k = 0; k < 30; k++) begin
      v = W'($urandom);
      send_byte(v);
      do_latch();
      off = 1'($urandom);
      hot = 1'($urandom);
      settle(GAP);
      chk("R4 random pattern (R11 latency)", chan_on, exp_chan(m_hold, off, hot));
      off = 1'b0; hot = 1'b0;
      settle(GAP);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule